// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the host-facing register file of a 16550-style UART that has been widened with extra configuration registers. A byte-wide bus carrying a 5-bit offset reaches more registers than it has offsets. Three bank conditions reuse offsets. The first is the line control value equal to the lock key 0xBF. The second is line control bit 7. The third is an enhanced-enable bit (bit 4 of the extended-feature register) together with modem control bit 6. At some offsets a read and a write also reach different registers.

The block holds the configuration registers and drives their values to the serial datapath. It returns status bytes that the datapath supplies. It also issues one-cycle strobes when the receive holding byte is read and when the transmit holding byte is written. The serializer, the FIFOs and the interrupt logic sit outside this block. Read data is combinational from the offset and the current bank state. Writes and strobes are registered.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset, line_ctl, modem_ctl and ext_feat read 0x00, divisor reads 0x0000 and mode_sel reads 0x07. Reading offset 0x08 returns 0x07.
- R2: In the default bank (line_ctl bit 7 clear), each of these offsets reads back what was last written to it: 0x01 int_en, 0x07 scratch, 0x08 mode_sel, 0x09 mode2, 0x0E blk_ctl, 0x0F aux_ctl, 0x10 supp_ctl, 0x12 ext_len.
- R3: Status reads pass through from the inputs. Offset 0x02 reads int_id, 0x05 reads line_stat and 0x06 reads modem_stat. Offset 0x0A+k (k=0..3) reads sup_stat[8k+7:8k]. Offset 0x11 reads {7'b0, tx_full}, so bit 0 is 1 while the transmit FIFO is full.
- R4: When line_ctl bit 7 is 1 and line_ctl is not 0xBF, three offsets change meaning. Offset 0x00 reaches divisor[7:0], offset 0x01 reaches divisor[15:8], and offset 0x0F reaches div_aux instead of aux_ctl.
- R5: When line_ctl is exactly 0xBF, five offsets change meaning for both reads and writes. Offset 0x02 reaches ext_feat. Offsets 0x04, 0x05, 0x06 and 0x07 reach flow_chr bytes 0 to 3 (two start characters, then two stop characters).
- R6: When ext_feat bit 4 and modem_ctl bit 6 are both 1 and line_ctl is not 0xBF, offset 0x06 reaches flow_thr and offset 0x07 reaches trig_lvl. This holds whatever line_ctl bit 7 is.
- R7: Bank priority is lock key first, then line_ctl bit 7, then the R6 condition, then the default map. While line_ctl is 0xBF, offsets 0x00, 0x01 and 0x0F read 0x00, ignore writes and raise no strobe.
- R8: A write to offset 0x02 in the default bank loads fifo_ctl only while ext_feat bit 4 is 1. Otherwise fifo_ctl is unchanged.
- R9: Writes to offset 0x0A+k load fifo_lvl byte k. Reads of those offsets still return the sup_stat bytes.
- R10: A read of offset 0x00 in the default bank makes rx_pop 1 for exactly the following cycle. The same read under line_ctl bit 7 leaves rx_pop at 0.
- R11: A write of offset 0x00 in the default bank makes tx_push 1 for exactly the following cycle, with tx_byte equal to the written byte. The same write under line_ctl bit 7 leaves tx_push at 0.
- R12: Offsets 0x13 to 0x1F read 0x00 and ignore writes. Writes to 0x05, 0x06 and 0x11 in the default bank change nothing.
- R13: Offset 0x03 reaches line_ctl in every bank, so every bank can be left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read access this cycle |
| wr_en | input | 1 | Write access this cycle |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| rx_byte | input | 8 | Head of receive FIFO |
| int_id | input | 8 | Interrupt identification byte |
| line_stat | input | 8 | Line status byte |
| modem_stat | input | 8 | Modem status byte |
| sup_stat | input | 32 | Four supplementary status bytes |
| tx_full | input | 1 | Transmit FIFO full |
| rx_pop | output | 1 | Receive holding byte consumed |
| tx_push | output | 1 | Transmit byte written |
| tx_byte | output | 8 | Byte to push |
| line_ctl | output | 8 | Line control |
| modem_ctl | output | 8 | Modem control |
| int_en | output | 8 | Interrupt enables |
| fifo_ctl | output | 8 | FIFO control |
| ext_feat | output | 8 | Extended features |
| divisor | output | 16 | Baud divisor |
| div_aux | output | 8 | Auxiliary divisor |
| flow_chr | output | 32 | Flow control characters |
| flow_thr | output | 8 | Flow halt/resume thresholds |
| trig_lvl | output | 8 | FIFO trigger levels |
| fifo_lvl | output | 32 | FIFO level triggers, 4 bytes |
| mode_sel | output | 8 | Operating mode |
| mode2 | output | 8 | Secondary mode |
| blk_ctl | output | 8 | Block control |
| aux_ctl | output | 8 | Auxiliary control |
| supp_ctl | output | 8 | Supplementary control |
| ext_len | output | 8 | Extended length |

## Verification
A wrong bank state inside this block always shows at the ports within one access. The next read at a shared offset returns a stored register where a status byte was expected, or the reverse. A misrouted write changes the wrong configuration output on the very next cycle, and a spurious or missing rx_pop or tx_push shows one cycle after the access. The bench therefore reads every shared offset in each bank and checks the neighbouring registers after each banked write. It also places the lock key, bit 7 and the threshold condition in overlap to expose a wrong priority.

// File: rtl/ubr_pkg.sv
`timescale 1ns/1ps
package ubr_pkg;
   localparam int BYTE_W   = 8;
   localparam int OFF_W    = 5;
   localparam int N_BYTE4  = 4;
   localparam logic [BYTE_W-1:0] LOCK_KEY = 8'hBF;
   localparam int ENH_BIT  = 4;
   localparam int THR_BIT  = 6;
   localparam int DL_BIT   = 7;

   typedef enum logic [4:0] {
      T_NONE, T_RHR, T_THR, T_IEN, T_IID, T_FCTL, T_LCTL, T_MCTL,
      T_LSTAT, T_MSTAT, T_SCRATCH, T_MODE, T_MODE2, T_SUP, T_FLVL,
      T_BLK, T_AUX, T_SUPC, T_SSTAT, T_ELEN, T_DLO, T_DHI, T_DAUX,
      T_EFEAT, T_FC0, T_FC1, T_FC2, T_FC3, T_FTHR, T_TLVL
   } tgt_e;

   typedef struct packed {
      logic key;
      logic dl;
      logic thr;
   } bank_t;

   function automatic tgt_e map_default(input logic [OFF_W-1:0] off, input logic is_wr);
      tgt_e t;
      case (off)
         5'h00: t = is_wr ? T_THR : T_RHR;
         5'h01: t = T_IEN;
         5'h02: t = is_wr ? T_FCTL : T_IID;
         5'h03: t = T_LCTL;
         5'h04: t = T_MCTL;
         5'h05: t = is_wr ? T_NONE : T_LSTAT;
         5'h06: t = is_wr ? T_NONE : T_MSTAT;
         5'h07: t = T_SCRATCH;
         5'h08: t = T_MODE;
         5'h09: t = T_MODE2;
         5'h0A, 5'h0B, 5'h0C, 5'h0D: t = is_wr ? T_FLVL : T_SUP;
         5'h0E: t = T_BLK;
         5'h0F: t = T_AUX;
         5'h10: t = T_SUPC;
         5'h11: t = is_wr ? T_NONE : T_SSTAT;
         5'h12: t = T_ELEN;
         default: t = T_NONE;
      endcase
      return t;
   endfunction
endpackage

// File: rtl/ubr_bank_sel.sv
`timescale 1ns/1ps
module ubr_bank_sel
   import ubr_pkg::*;
(
   input  logic [BYTE_W-1:0] line_ctl,
   input  logic [BYTE_W-1:0] modem_ctl,
   input  logic [BYTE_W-1:0] ext_feat,
   output bank_t             bank
);
   logic key_hit;
   assign key_hit  = (line_ctl == LOCK_KEY);
   assign bank.key = key_hit;
   assign bank.dl  = line_ctl[DL_BIT] & ~key_hit;
   assign bank.thr = ext_feat[ENH_BIT] & modem_ctl[THR_BIT];
endmodule

// File: rtl/ubr_decode.sv
`timescale 1ns/1ps
module ubr_decode
   import ubr_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter bit IS_WR  = 1'b0
)(
   input  logic [ADDR_W-1:0] addr,
   input  bank_t             bank,
   output tgt_e              tgt
);
   logic [OFF_W-1:0] off;
   logic             hi_set;

   assign off = addr[OFF_W-1:0];

   generate
      if (ADDR_W > OFF_W) begin : g_hi
         assign hi_set = |addr[ADDR_W-1:OFF_W];
      end else begin : g_nohi
         assign hi_set = 1'b0;
      end
   endgenerate

   always_comb begin
      tgt = map_default(off, IS_WR);
      if (bank.thr) begin
         case (off)
            5'h06: tgt = T_FTHR;
            5'h07: tgt = T_TLVL;
            default: ;
         endcase
      end
      if (bank.dl) begin
         case (off)
            5'h00: tgt = T_DLO;
            5'h01: tgt = T_DHI;
            5'h0F: tgt = T_DAUX;
            default: ;
         endcase
      end
      if (bank.key) begin
         case (off)
            5'h00, 5'h01, 5'h0F: tgt = T_NONE;
            5'h02: tgt = T_EFEAT;
            5'h04: tgt = T_FC0;
            5'h05: tgt = T_FC1;
            5'h06: tgt = T_FC2;
            5'h07: tgt = T_FC3;
            default: ;
         endcase
      end
      if (hi_set) tgt = T_NONE;
   end
endmodule

// File: rtl/ubr_regfile.sv
`timescale 1ns/1ps
module ubr_regfile
   import ubr_pkg::*;
#(
   parameter logic [BYTE_W-1:0] MODE_RST = 8'h07
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  tgt_e                      wr_sel,
   input  logic [1:0]                lane,
   input  logic [BYTE_W-1:0]         wdata,
   output logic [BYTE_W-1:0]         line_ctl,
   output logic [BYTE_W-1:0]         modem_ctl,
   output logic [BYTE_W-1:0]         int_en,
   output logic [BYTE_W-1:0]         fifo_ctl,
   output logic [BYTE_W-1:0]         ext_feat,
   output logic [2*BYTE_W-1:0]       divisor,
   output logic [BYTE_W-1:0]         div_aux,
   output logic [N_BYTE4*BYTE_W-1:0] flow_chr,
   output logic [BYTE_W-1:0]         flow_thr,
   output logic [BYTE_W-1:0]         trig_lvl,
   output logic [N_BYTE4*BYTE_W-1:0] fifo_lvl,
   output logic [BYTE_W-1:0]         mode_sel,
   output logic [BYTE_W-1:0]         mode2,
   output logic [BYTE_W-1:0]         scratch,
   output logic [BYTE_W-1:0]         blk_ctl,
   output logic [BYTE_W-1:0]         aux_ctl,
   output logic [BYTE_W-1:0]         supp_ctl,
   output logic [BYTE_W-1:0]         ext_len
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_ctl  <= '0;
         modem_ctl <= '0;
         int_en    <= '0;
         fifo_ctl  <= '0;
         ext_feat  <= '0;
         divisor   <= '0;
         div_aux   <= '0;
         flow_thr  <= '0;
         trig_lvl  <= '0;
         mode_sel  <= MODE_RST;
         mode2     <= '0;
         scratch   <= '0;
         blk_ctl   <= '0;
         aux_ctl   <= '0;
         supp_ctl  <= '0;
         ext_len   <= '0;
      end else begin
         case (wr_sel)
            T_LCTL:    line_ctl  <= wdata;
            T_MCTL:    modem_ctl <= wdata;
            T_IEN:     int_en    <= wdata;
            T_FCTL:    if (ext_feat[ENH_BIT]) fifo_ctl <= wdata;
            T_EFEAT:   ext_feat  <= wdata;
            T_DLO:     divisor[BYTE_W-1:0]        <= wdata;
            T_DHI:     divisor[2*BYTE_W-1:BYTE_W] <= wdata;
            T_DAUX:    div_aux   <= wdata;
            T_FTHR:    flow_thr  <= wdata;
            T_TLVL:    trig_lvl  <= wdata;
            T_MODE:    mode_sel  <= wdata;
            T_MODE2:   mode2     <= wdata;
            T_SCRATCH: scratch   <= wdata;
            T_BLK:     blk_ctl   <= wdata;
            T_AUX:     aux_ctl   <= wdata;
            T_SUPC:    supp_ctl  <= wdata;
            T_ELEN:    ext_len   <= wdata;
            default: ;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < N_BYTE4; g++) begin : g_b4
         localparam tgt_e FC_T = tgt_e'(int'(T_FC0) + g);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flow_chr[g*BYTE_W +: BYTE_W] <= '0;
               fifo_lvl[g*BYTE_W +: BYTE_W] <= '0;
            end else begin
               if (wr_sel == FC_T)
                  flow_chr[g*BYTE_W +: BYTE_W] <= wdata;
               if (wr_sel == T_FLVL && lane == 2'(g))
                  fifo_lvl[g*BYTE_W +: BYTE_W] <= wdata;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/uart_bank_regs.sv
`timescale 1ns/1ps
module uart_bank_regs
   import ubr_pkg::*;
#(
   parameter int                ADDR_W    = 5,
   parameter bit                RDATA_REG = 1'b0,
   parameter logic [BYTE_W-1:0] MODE_RST  = 8'h07
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_en,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [BYTE_W-1:0]         wdata,
   output logic [BYTE_W-1:0]         rdata,
   input  logic [BYTE_W-1:0]         rx_byte,
   input  logic [BYTE_W-1:0]         int_id,
   input  logic [BYTE_W-1:0]         line_stat,
   input  logic [BYTE_W-1:0]         modem_stat,
   input  logic [N_BYTE4*BYTE_W-1:0] sup_stat,
   input  logic                      tx_full,
   output logic                      rx_pop,
   output logic                      tx_push,
   output logic [BYTE_W-1:0]         tx_byte,
   output logic [BYTE_W-1:0]         line_ctl,
   output logic [BYTE_W-1:0]         modem_ctl,
   output logic [BYTE_W-1:0]         int_en,
   output logic [BYTE_W-1:0]         fifo_ctl,
   output logic [BYTE_W-1:0]         ext_feat,
   output logic [2*BYTE_W-1:0]       divisor,
   output logic [BYTE_W-1:0]         div_aux,
   output logic [N_BYTE4*BYTE_W-1:0] flow_chr,
   output logic [BYTE_W-1:0]         flow_thr,
   output logic [BYTE_W-1:0]         trig_lvl,
   output logic [N_BYTE4*BYTE_W-1:0] fifo_lvl,
   output logic [BYTE_W-1:0]         mode_sel,
   output logic [BYTE_W-1:0]         mode2,
   output logic [BYTE_W-1:0]         blk_ctl,
   output logic [BYTE_W-1:0]         aux_ctl,
   output logic [BYTE_W-1:0]         supp_ctl,
   output logic [BYTE_W-1:0]         ext_len
);
   generate
      if (ADDR_W < OFF_W) begin : g_bad_addr
         $error("uart_bank_regs: ADDR_W must cover offsets up to 0x12");
      end
   endgenerate

   bank_t             bank;
   tgt_e              rd_tgt, wr_tgt, wr_sel;
   logic [1:0]        lane;
   logic [BYTE_W-1:0] scratch;
   logic [BYTE_W-1:0] rd_mux;
   logic              pop_q, push_q;
   logic [BYTE_W-1:0] byte_q;

   assign lane   = 2'(addr[1:0] + 2'd2);
   assign wr_sel = wr_en ? wr_tgt : T_NONE;

   ubr_bank_sel i_bank (
      .line_ctl (line_ctl),
      .modem_ctl(modem_ctl),
      .ext_feat (ext_feat),
      .bank     (bank)
   );

   ubr_decode #(.ADDR_W(ADDR_W), .IS_WR(1'b0)) i_rd_dec (
      .addr(addr), .bank(bank), .tgt(rd_tgt)
   );

   ubr_decode #(.ADDR_W(ADDR_W), .IS_WR(1'b1)) i_wr_dec (
      .addr(addr), .bank(bank), .tgt(wr_tgt)
   );

   ubr_regfile #(.MODE_RST(MODE_RST)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (wr_sel),
      .lane     (lane),
      .wdata    (wdata),
      .line_ctl (line_ctl),
      .modem_ctl(modem_ctl),
      .int_en   (int_en),
      .fifo_ctl (fifo_ctl),
      .ext_feat (ext_feat),
      .divisor  (divisor),
      .div_aux  (div_aux),
      .flow_chr (flow_chr),
      .flow_thr (flow_thr),
      .trig_lvl (trig_lvl),
      .fifo_lvl (fifo_lvl),
      .mode_sel (mode_sel),
      .mode2    (mode2),
      .scratch  (scratch),
      .blk_ctl  (blk_ctl),
      .aux_ctl  (aux_ctl),
      .supp_ctl (supp_ctl),
      .ext_len  (ext_len)
   );

   always_comb begin
      case (rd_tgt)
         T_RHR:     rd_mux = rx_byte;
         T_IEN:     rd_mux = int_en;
         T_IID:     rd_mux = int_id;
         T_LCTL:    rd_mux = line_ctl;
         T_MCTL:    rd_mux = modem_ctl;
         T_LSTAT:   rd_mux = line_stat;
         T_MSTAT:   rd_mux = modem_stat;
         T_SCRATCH: rd_mux = scratch;
         T_MODE:    rd_mux = mode_sel;
         T_MODE2:   rd_mux = mode2;
         T_SUP:     rd_mux = sup_stat[lane*BYTE_W +: BYTE_W];
         T_BLK:     rd_mux = blk_ctl;
         T_AUX:     rd_mux = aux_ctl;
         T_SUPC:    rd_mux = supp_ctl;
         T_SSTAT:   rd_mux = {{(BYTE_W-1){1'b0}}, tx_full};
         T_ELEN:    rd_mux = ext_len;
         T_DLO:     rd_mux = divisor[BYTE_W-1:0];
         T_DHI:     rd_mux = divisor[2*BYTE_W-1:BYTE_W];
         T_DAUX:    rd_mux = div_aux;
         T_EFEAT:   rd_mux = ext_feat;
         T_FC0:     rd_mux = flow_chr[0*BYTE_W +: BYTE_W];
         T_FC1:     rd_mux = flow_chr[1*BYTE_W +: BYTE_W];
         T_FC2:     rd_mux = flow_chr[2*BYTE_W +: BYTE_W];
         T_FC3:     rd_mux = flow_chr[3*BYTE_W +: BYTE_W];
         T_FTHR:    rd_mux = flow_thr;
         T_TLVL:    rd_mux = trig_lvl;
         default:   rd_mux = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_en) rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_q  <= 1'b0;
         push_q <= 1'b0;
         byte_q <= '0;
      end else begin
         pop_q  <= rd_en && (rd_tgt == T_RHR);
         push_q <= wr_en && (wr_tgt == T_THR);
         if (wr_en && wr_tgt == T_THR) byte_q <= wdata;
      end
   end

   assign rx_pop  = pop_q;
   assign tx_push = push_q;
   assign tx_byte = byte_q;
endmodule

// File: rtl/ubr_checker.sv
`timescale 1ns/1ps
module ubr_checker #(
   parameter int ADDR_W    = 5,
   parameter bit RDATA_REG = 1'b0
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic              rx_pop,
   input logic              tx_push,
   input logic [7:0]        tx_byte,
   input logic [7:0]        line_ctl,
   input logic [7:0]        ext_feat,
   input logic [7:0]        fifo_ctl,
   input logic [15:0]       divisor,
   input logic [7:0]        int_en,
   input logic [7:0]        mode_sel
);
   // R10: a pop only follows a read of offset 0 with line_ctl bit 7 clear
   a_r10_pop_src: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> $past(rd_en && addr == ADDR_W'(0) && !line_ctl[7]));

   // R10: the pop is a single-cycle pulse while reads are not back to back
   a_r10_pop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && !$past(rd_en, 2)) |=> !rx_pop || $past(rd_en));

   // R11: a push only follows a write of offset 0 with line_ctl bit 7 clear
   a_r11_push_src: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> $past(wr_en && addr == ADDR_W'(0) && !line_ctl[7]));

   // R11: pushed byte is the byte written
   a_r11_push_data: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> tx_byte == $past(wdata));

   // R8: FIFO control write is blocked without the enhanced bit
   a_r8_fifo_ctl_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(2) && line_ctl != 8'hBF && !ext_feat[4]) |=> $stable(fifo_ctl));

   // R4: divisor low byte write in the divisor bank
   a_r4_div_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(0) && line_ctl[7] && line_ctl != 8'hBF)
         |=> divisor[7:0] == $past(wdata));

   // R12: writes above 0x12 leave configuration unchanged
   a_r12_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr > ADDR_W'(18)) |=>
         ($stable(line_ctl) && $stable(int_en) && $stable(mode_sel) && $stable(divisor)));

   generate
      if (!RDATA_REG) begin : g_comb_rd
         // R12: unmapped offsets read zero
         a_r12_unmapped_rd: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr > ADDR_W'(18)) |-> rdata == 8'h00);
      end
   endgenerate
endmodule

bind uart_bank_regs ubr_checker #(.ADDR_W(ADDR_W), .RDATA_REG(RDATA_REG)) i_ubr_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .rx_pop   (rx_pop),
   .tx_push  (tx_push),
   .tx_byte  (tx_byte),
   .line_ctl (line_ctl),
   .ext_feat (ext_feat),
   .fifo_ctl (fifo_ctl),
   .divisor  (divisor),
   .int_en   (int_en),
   .mode_sel (mode_sel)
);

// File: tb/test_uart_bank_regs.sv
`timescale 1ns/1ps
module test_uart_bank_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [7:0]  wdata = '0, rdata;
   logic [7:0]  rx_byte = '0, int_id = '0, line_stat = '0, modem_stat = '0;
   logic [31:0] sup_stat = '0;
   logic        tx_full = 1'b0;
   logic        rx_pop, tx_push;
   logic [7:0]  tx_byte, line_ctl, modem_ctl, int_en, fifo_ctl, ext_feat, div_aux;
   logic [15:0] divisor;
   logic [31:0] flow_chr, fifo_lvl;
   logic [7:0]  flow_thr, trig_lvl, mode_sel, mode2, blk_ctl, aux_ctl, supp_ctl, ext_len;

   always #2.5 clk = ~clk;

   uart_bank_regs i_uart_bank_regs (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .int_id(int_id),
      .line_stat(line_stat), .modem_stat(modem_stat), .sup_stat(sup_stat),
      .tx_full(tx_full), .rx_pop(rx_pop), .tx_push(tx_push), .tx_byte(tx_byte),
      .line_ctl(line_ctl), .modem_ctl(modem_ctl), .int_en(int_en),
      .fifo_ctl(fifo_ctl), .ext_feat(ext_feat), .divisor(divisor),
      .div_aux(div_aux), .flow_chr(flow_chr), .flow_thr(flow_thr),
      .trig_lvl(trig_lvl), .fifo_lvl(fifo_lvl), .mode_sel(mode_sel),
      .mode2(mode2), .blk_ctl(blk_ctl), .aux_ctl(aux_ctl),
      .supp_ctl(supp_ctl), .ext_len(ext_len)
   );

   localparam int S_RD = 0, S_POP = 1, S_PUSH = 2, S_TXB = 3, S_LCTL = 4,
                  S_MCTL = 5, S_EFEAT = 6, S_MODE = 7, S_DIV = 8, S_FCTL = 9,
                  S_FCHR = 10, S_FLVL = 11, S_FTHR = 12, S_TLVL = 13,
                  S_DAUX = 14, S_AUX = 15, S_IEN = 16;

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   int n_run = 0, n_fail = 0;
   bit done = 0;

   function automatic logic [31:0] port_val(input int sel);
      case (sel)
         S_RD:    return {24'h0, rdata};
         S_POP:   return {31'h0, rx_pop};
         S_PUSH:  return {31'h0, tx_push};
         S_TXB:   return {24'h0, tx_byte};
         S_LCTL:  return {24'h0, line_ctl};
         S_MCTL:  return {24'h0, modem_ctl};
         S_EFEAT: return {24'h0, ext_feat};
         S_MODE:  return {24'h0, mode_sel};
         S_DIV:   return {16'h0, divisor};
         S_FCTL:  return {24'h0, fifo_ctl};
         S_FCHR:  return flow_chr;
         S_FLVL:  return fifo_lvl;
         S_FTHR:  return {24'h0, flow_thr};
         S_TLVL:  return {24'h0, trig_lvl};
         S_DAUX:  return {24'h0, div_aux};
         S_AUX:   return {24'h0, aux_ctl};
         S_IEN:   return {24'h0, int_en};
         default: return 32'hDEAD_BEEF;
      endcase
   endfunction

   // monitor: compare queued expectations away from the active edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it  = sb.pop_front();
         got = port_val(it.sel);
         n_run++;
         if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
         end
      end
   end

   task automatic expect_port(input int sel, input logic [31:0] exp, input string tag);
      item_t it;
      it.sel = sel; it.exp = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      step();
      addr = a; wdata = d; wr_en = 1'b1;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
      step();
      addr = a; rd_en = 1'b1;
      expect_port(S_RD, {24'h0, exp}, tag);
      step();
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      expect_port(S_LCTL, 32'h00, "R1 line_ctl reset");
      expect_port(S_MCTL, 32'h00, "R1 modem_ctl reset");
      expect_port(S_EFEAT, 32'h00, "R1 ext_feat reset");
      expect_port(S_MODE, 32'h07, "R1 mode_sel reset");
      expect_port(S_DIV, 32'h0000, "R1 divisor reset");
      rd(5'h08, 8'h07, "R1 read mode_sel reset");

      // R2 default-bank read back
      wr(5'h01, 8'h5A); rd(5'h01, 8'h5A, "R2 int_en");
      wr(5'h07, 8'hA5); rd(5'h07, 8'hA5, "R2 scratch");
      wr(5'h09, 8'h33); rd(5'h09, 8'h33, "R2 mode2");
      wr(5'h0E, 8'h44); rd(5'h0E, 8'h44, "R2 blk_ctl");
      wr(5'h0F, 8'h55); rd(5'h0F, 8'h55, "R2 aux_ctl");
      wr(5'h10, 8'h66); rd(5'h10, 8'h66, "R2 supp_ctl");
      wr(5'h12, 8'h77); rd(5'h12, 8'h77, "R2 ext_len");
      wr(5'h08, 8'h00); expect_port(S_MODE, 32'h00, "R2 mode_sel write");

      // R3 status pass-through
      int_id = 8'hC1; line_stat = 8'h60; modem_stat = 8'hB0;
      sup_stat = 32'h4433_2211; tx_full = 1'b1;
      rd(5'h02, 8'hC1, "R3 int_id");
      rd(5'h05, 8'h60, "R3 line_stat");
      rd(5'h06, 8'hB0, "R3 modem_stat");
      rd(5'h0A, 8'h11, "R3 sup byte0");
      rd(5'h0B, 8'h22, "R3 sup byte1");
      rd(5'h0C, 8'h33, "R3 sup byte2");
      rd(5'h0D, 8'h44, "R3 sup byte3");
      rd(5'h11, 8'h01, "R3 tx_full set");
      tx_full = 1'b0;
      rd(5'h11, 8'h00, "R3 tx_full clear");

      // R9 trigger-level writes
      wr(5'h0A, 8'h91); wr(5'h0B, 8'h92); wr(5'h0C, 8'h93); wr(5'h0D, 8'h94);
      expect_port(S_FLVL, 32'h9493_9291, "R9 fifo_lvl");
      rd(5'h0A, 8'h11, "R9 read still status");

      // R8 blocked without enhanced bit
      wr(5'h02, 8'hE7); expect_port(S_FCTL, 32'h00, "R8 fifo_ctl blocked");

      // R5 lock-key bank
      wr(5'h04, 8'h40); expect_port(S_MCTL, 32'h40, "R5 modem_ctl setup");
      wr(5'h03, 8'hBF); expect_port(S_LCTL, 32'hBF, "R13 line_ctl key");
      wr(5'h02, 8'h10); expect_port(S_EFEAT, 32'h10, "R5 ext_feat write");
      wr(5'h04, 8'hA1); wr(5'h05, 8'hA2); wr(5'h06, 8'hA3); wr(5'h07, 8'hA4);
      expect_port(S_FCHR, 32'hA4A3_A2A1, "R5 flow_chr");
      expect_port(S_MCTL, 32'h40, "R5 modem_ctl untouched");
      rd(5'h02, 8'h10, "R5 read ext_feat");
      rd(5'h05, 8'hA2, "R5 read flow byte1");
      // R7 priority and holes
      rd(5'h06, 8'hA3, "R7 key wins over thresholds");
      rx_byte = 8'h3C;
      rd(5'h00, 8'h00, "R7 offset 0 hole");
      expect_port(S_POP, 32'h0, "R7 no pop under key");
      wr(5'h01, 8'hEE); expect_port(S_IEN, 32'h5A, "R7 offset 1 ignored");
      wr(5'h0F, 8'hEE); expect_port(S_AUX, 32'h55, "R7 offset F ignored");
      expect_port(S_DAUX, 32'h00, "R7 div_aux untouched");
      wr(5'h03, 8'h00); expect_port(S_LCTL, 32'h00, "R13 leave key bank");

      // R8 allowed with enhanced bit
      wr(5'h02, 8'hC9); expect_port(S_FCTL, 32'hC9, "R8 fifo_ctl loaded");

      // R6 threshold bank
      wr(5'h06, 8'h21); wr(5'h07, 8'h43);
      expect_port(S_FTHR, 32'h21, "R6 flow_thr");
      expect_port(S_TLVL, 32'h43, "R6 trig_lvl");
      rd(5'h06, 8'h21, "R6 read flow_thr");
      wr(5'h03, 8'h83);
      rd(5'h07, 8'h43, "R6 trig_lvl under bit7");
      wr(5'h03, 8'h00);
      wr(5'h04, 8'h00);
      rd(5'h06, 8'hB0, "R6 bank off reads modem_stat");
      rd(5'h07, 8'hA5, "R6 bank off reads scratch");

      // R4 divisor bank
      wr(5'h03, 8'h80);
      wr(5'h00, 8'h15);
      expect_port(S_PUSH, 32'h0, "R11 no push under bit7");
      wr(5'h01, 8'h02); wr(5'h0F, 8'h99);
      expect_port(S_DIV, 32'h0215, "R4 divisor");
      expect_port(S_DAUX, 32'h99, "R4 div_aux");
      expect_port(S_AUX, 32'h55, "R4 aux_ctl kept");
      expect_port(S_IEN, 32'h5A, "R4 int_en kept");
      rd(5'h00, 8'h15, "R4 read divisor low");
      expect_port(S_POP, 32'h0, "R10 no pop under bit7");
      rd(5'h01, 8'h02, "R4 read divisor high");
      rd(5'h0F, 8'h99, "R4 read div_aux");
      wr(5'h03, 8'h03);
      rd(5'h0F, 8'h55, "R4 default aux_ctl back");

      // R10 pop strobe
      rd(5'h00, 8'h3C, "R10 read rx_byte");
      expect_port(S_POP, 32'h1, "R10 pop pulse");
      step();
      expect_port(S_POP, 32'h0, "R10 pop one cycle");

      // R11 push strobe
      wr(5'h00, 8'h6B);
      expect_port(S_PUSH, 32'h1, "R11 push pulse");
      expect_port(S_TXB, 32'h6B, "R11 tx_byte");
      step();
      expect_port(S_PUSH, 32'h0, "R11 push one cycle");

      // R12 unmapped and read-only
      rd(5'h13, 8'h00, "R12 read 0x13");
      rd(5'h1F, 8'h00, "R12 read 0x1F");
      wr(5'h15, 8'hFF);
      expect_port(S_LCTL, 32'h03, "R12 line_ctl kept");
      expect_port(S_IEN, 32'h5A, "R12 int_en kept");
      wr(5'h05, 8'hFF); rd(5'h05, 8'h60, "R12 line_stat read-only");
      wr(5'h11, 8'hFF); rd(5'h11, 8'h00, "R12 supp status read-only");

      step(); step();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule